// File: doc/BRIEF.md
# Daisy-Chainable Converter Serial Output Port

This block models the digital side of one sampling converter that can sit in a daisy chain of identical devices sharing a three-wire serial link. A rising edge on the convert strobe, taken while the serial clock is low, starts a conversion of fixed length. When that time has run out, a 16-bit sample supplied from outside is loaded into a result shift register, and its most significant bit is presented on the serial output. Every later falling edge of the serial clock moves the register one place toward the output. The serial input enters at the least significant end, so the words of the devices further up the chain follow this device's own word on the same wire.

The convert strobe, serial clock and serial input are brought through a two-stage synchronizer into a faster system clock domain, and all edges are detected there. The controller under test sees the port react within three system clocks of any pin change. A convert edge taken while the serial clock is high selects a mode this port does not support. The port flags that mode and then ignores the serial clock until the strobe drops.

States: `ST_IDLE` (waiting, output held low), `ST_CONVERT` (timer running), `ST_READOUT` (acquisition and shift-out) and `ST_FAULT` (unsupported mode). Transitions: IDLE to CONVERT on a strobe rise with the serial clock low. IDLE to FAULT on a strobe rise with the serial clock high. CONVERT to READOUT when the timer expires, which loads the sample. CONVERT, READOUT or FAULT to IDLE when the strobe falls.

Top module: `chain_adc_port`

## Requirements
- R1: After reset the port is in ST_IDLE with `sdo_out` = 0 and `mode_fault` = 0.
- R2: While the synchronized strobe and the synchronized serial input are both low, `sdo_out` is 0. Outside ST_READOUT, `sdo_out` is always 0.
- R3: A strobe rise seen while the serial clock is low enters ST_CONVERT for CONV_CYCLES system clocks. The port then loads `sample_in` and shows its bit 15 on `sdo_out`.
- R4: In ST_READOUT, each serial clock falling edge shifts the register by one bit toward the output. The word appears on `sdo_out` MSB first, bit 15 down to bit 0.
- R5: The serial input is taken in at bit 0 on each falling edge. After 16 falling edges, `sdo_out` carries the upstream word MSB first, so N chained ports are read out in 16×N edges.
- R6: Serial clock edges during ST_CONVERT have no effect. After the conversion, the full loaded word is still read out intact, starting with bit 15.
- R7: A strobe rise seen while the serial clock is high enters ST_FAULT. In ST_FAULT, `mode_fault` = 1, `sdo_out` stays 0 and serial clock edges shift nothing. A strobe fall returns the port to ST_IDLE with `mode_fault` = 0.
- R8: A strobe fall during ST_CONVERT or ST_READOUT returns the port to ST_IDLE, which ends the readout.
- R9: Rising edges of the serial clock never shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_in | input | 1 | Convert strobe from the controller (asynchronous) |
| sck_in | input | 1 | Serial clock from the controller (asynchronous) |
| sdi_in | input | 1 | Serial data from the upstream device |
| sample_in | input | 16 | Result word loaded when the conversion ends |
| sdo_out | output | 1 | Serial data toward the downstream device or the controller |
| mode_fault | output | 1 | High while an unsupported mode is selected |

## Verification
The assertions check every cycle that state transitions follow the strobe edges and the serial clock level, and that the conversion timer loads its limit and counts down one per clock. They also check that every shift moves the old bits up and brings in the synchronized serial input, and that the output is low whenever the strobe and serial input are both low. Only the bench scenarios can show complete behaviours at the pins. These are the readout order of whole words, and the cascade of an upstream word through the register. They also include edges ignored during conversion or in the fault state, and the abort and restart caused by a strobe fall.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_READOUT = 2'd2,
        ST_FAULT   = 2'd3
    } port_state_e;

    localparam int SYNC_CNV = 0;
    localparam int SYNC_SCK = 1;
    localparam int SYNC_SDI = 2;
    localparam int SYNC_W   = 3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta        <= 1'b0;
                lvl[g]      <= 1'b0;
                lvl_prev[g] <= 1'b0;
            end else begin
                meta        <= pins[g];
                lvl[g]      <= meta;
                lvl_prev[g] <= lvl[g];
            end
        end
    end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= LAST;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign done = running && (cnt == '0);

    assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && cnt == LAST));
    assert_timer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt != '0 && !start) |=> (running && cnt == $past(cnt) - 1'b1));
    assert_timer_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !running);
endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] par_in,
    input  logic         shift,
    input  logic         ser_in,
    output logic         msb
);
    logic [W-1:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     word <= '0;
        else if (load)  word <= par_in;
        else if (shift) word <= {word[W-2:0], ser_in};
    end

    assign msb = word[W-1];

    assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (word == {$past(word[W-2:0]), $past(ser_in)}));
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !load) |=> $stable(word));
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_in,
    input  logic              sck_in,
    input  logic              sdi_in,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo_out,
    output logic              mode_fault
);
    import chain_port_pkg::*;

    port_state_e state, state_nx;
    logic [SYNC_W-1:0] lvl, lvl_prev;
    logic cnv_lvl, sck_lvl, sdi_lvl;
    logic cnv_rise, cnv_fall, sck_fall;
    logic conv_start, conv_done, load_word, shift_en, word_msb;

    pin_sync #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pins({sdi_in, sck_in, cnv_in}),
        .lvl(lvl), .lvl_prev(lvl_prev)
    );

    assign cnv_lvl  = lvl[SYNC_CNV];
    assign sck_lvl  = lvl[SYNC_SCK];
    assign sdi_lvl  = lvl[SYNC_SDI];
    assign cnv_rise = cnv_lvl & ~lvl_prev[SYNC_CNV];
    assign cnv_fall = ~cnv_lvl & lvl_prev[SYNC_CNV];
    assign sck_fall = ~sck_lvl & lvl_prev[SYNC_SCK];

    assign conv_start = (state == ST_IDLE) && cnv_rise && !sck_lvl;
    assign load_word  = (state == ST_CONVERT) && conv_done && !cnv_fall;
    assign shift_en   = (state == ST_READOUT) && sck_fall && !cnv_fall;

    conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(conv_start), .done(conv_done)
    );

    result_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(load_word), .par_in(sample_in),
        .shift(shift_en), .ser_in(sdi_lvl),
        .msb(word_msb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cnv_rise) state_nx = sck_lvl ? ST_FAULT : ST_CONVERT;
            end
            ST_CONVERT: begin
                if (cnv_fall)       state_nx = ST_IDLE;
                else if (conv_done) state_nx = ST_READOUT;
            end
            ST_READOUT: begin
                if (cnv_fall) state_nx = ST_IDLE;
            end
            ST_FAULT: begin
                if (cnv_fall) state_nx = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        mode_fault = (state == ST_FAULT);
        sdo_out    = (state == ST_READOUT) && (cnv_lvl || sdi_lvl) && word_msb;
    end

    assert_low_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_lvl && !sdi_lvl) |-> !sdo_out);
    assert_enter_convert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cnv_rise && !sck_lvl) |=> (state == ST_CONVERT));
    assert_convert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && !conv_done && !cnv_fall) |=> (state == ST_CONVERT && !sdo_out));
    assert_enter_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cnv_rise && sck_lvl) |=> mode_fault);
    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |-> !sdo_out);
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cnv_fall) |=> (state == ST_IDLE));
endmodule

// File: tb/test_chain_adc_port.sv
module test_chain_adc_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic [15:0] sample = '0;
    logic        sdo, fault;
    int          n_checks = 0, n_fail = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    chain_adc_port #(.DATA_W(16), .CONV_CYCLES(20)) i_chain_adc_port (
        .clk(clk), .rst_n(rst_n), .cnv_in(cnv), .sck_in(sck), .sdi_in(sdi),
        .sample_in(sample), .sdo_out(sdo), .mode_fault(fault)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // one serial clock pulse: rise, then fall; sdi presented with the rise
    task automatic sck_pulse(input logic din);
        sdi = din; sck = 1'b1; cyc(4);
        sck = 1'b0; cyc(4);
    endtask

    // strobe rise with sck low; wait past the 20-clock conversion plus sync latency
    task automatic start_conv(input logic [15:0] w);
        sample = w; sck = 1'b0; cyc(4);
        cnv = 1'b1; cyc(30);
    endtask

    task automatic end_frame();
        cnv = 1'b0; sdi = 1'b0; sck = 1'b0; cyc(6);
    endtask

    task automatic t_reset();
        check("R1 sdo in reset", sdo, 1'b0);
        check("R1 fault in reset", fault, 1'b0);
        rst_n = 1'b1; cyc(4);
        check("R1 sdo after reset", sdo, 1'b0);
        check("R1 fault after reset", fault, 1'b0);
    endtask

    task automatic t_idle_low();
        cnv = 1'b0; sdi = 1'b0; cyc(5);
        check("R2 sdo low with cnv and sdi low", sdo, 1'b0);
        sdi = 1'b1; cyc(5);
        check("R2 sdo low outside readout", sdo, 1'b0);
        sdi = 1'b0; cyc(2);
    endtask

    task automatic t_read_word(input logic [15:0] w);
        start_conv(w);
        check("R3 msb after conversion", sdo, w[15]);
        sck = 1'b1; cyc(5);
        check("R9 rising edge does not shift", sdo, w[15]);
        sck = 1'b0; cyc(4);
        check("R4 bit 14 after first fall", sdo, w[14]);
        for (int i = 2; i < 16; i++) begin
            sck_pulse(1'b0);
            check("R4 readout bit", sdo, w[15-i]);
        end
        end_frame();
    endtask

    task automatic t_chain(input logic [15:0] own, input logic [15:0] up);
        start_conv(own);
        check("R5 own msb first", sdo, own[15]);
        for (int k = 1; k <= 32; k++) begin
            sck_pulse((k <= 16) ? up[16-k] : 1'b0);
            if (k < 16)       check("R5 own word bit", sdo, own[15-k]);
            else if (k <= 31) check("R5 upstream word bit", sdo, up[31-k]);
        end
        end_frame();
    endtask

    task automatic t_ignore_conv(input logic [15:0] w);
        sample = w; sck = 1'b0; cyc(4);
        cnv = 1'b1; cyc(3);
        for (int i = 0; i < 3; i++) begin
            sdi = 1'b1; sck = 1'b1; cyc(2);
            sck = 1'b0; cyc(2);
        end
        sdi = 1'b0; cyc(15);
        check("R6 msb intact after edges in conversion", sdo, w[15]);
        for (int i = 1; i < 16; i++) begin
            sck_pulse(1'b0);
            check("R6 word intact", sdo, w[15-i]);
        end
        end_frame();
    endtask

    task automatic t_fault();
        sample = 16'hFFFF; sck = 1'b1; cyc(5);
        cnv = 1'b1; cyc(30);
        check("R7 fault flagged", fault, 1'b1);
        check("R7 sdo low in fault", sdo, 1'b0);
        sck = 1'b0; cyc(4);
        for (int i = 0; i < 4; i++) begin
            sck_pulse(1'b1);
            check("R7 no shift in fault", sdo, 1'b0);
        end
        cnv = 1'b0; sdi = 1'b0; cyc(5);
        check("R7 fault cleared on strobe fall", fault, 1'b0);
        check("R7 sdo low after fault", sdo, 1'b0);
    endtask

    task automatic t_abort(input logic [15:0] w);
        start_conv(w);
        sck_pulse(1'b1);
        check("R8 readout running before abort", sdo, w[14]);
        cnv = 1'b0; sdi = 1'b0; cyc(5);
        check("R8 sdo low after abort", sdo, 1'b0);
        sdi = 1'b1; cyc(5);
        check("R8 stays idle after abort", sdo, 1'b0);
        sdi = 1'b0;
        start_conv(~w);
        check("R8 restart loads new word", sdo, ~w[15]);
        end_frame();
        // abort inside conversion: no readout appears
        sample = 16'hFFFF; cnv = 1'b1; cyc(10);
        cnv = 1'b0; cyc(25);
        check("R8 abort during conversion", sdo, 1'b0);
        sdi = 1'b1; cyc(4);
        check("R8 no late load after abort", sdo, 1'b0);
        sdi = 1'b0; cyc(2);
    endtask

    initial begin
        cyc(3);
        t_reset();
        t_idle_low();
        t_read_word(16'hA5C3);
        t_read_word(16'h5A3C);
        t_chain(16'h8001, 16'hC35A);
        t_ignore_conv(16'hB00D);
        t_fault();
        t_abort(16'h9F60);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule